// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block lets a byte-wide memory sit on a two-wire serial bus as a slave. A fast system clock samples the bus clock and data lines through a short synchronizer. The block finds start and stop conditions and frames bits into bytes. It checks the device address, loads a word pointer from two address bytes and answers each byte with an acknowledge or a negative acknowledge. The bus data line is driven only through an active-high pull-down enable, so the pad stays open-drain.

Write bytes are handed to the memory side as single-cycle requests. Read bytes are fetched through a request that returns data one cycle later. A stop that ends a write with data raises a one-cycle pulse to start the programming controller. While that controller reports busy, the block does not answer its own address. A master can therefore poll with address bytes until it gets an acknowledge.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data enable is low. A start condition (data falling while the bus clock is high) restarts device-address reception from any state, also partway through a byte. A stop condition (data rising while the clock is high) returns the block to idle with the data line released.
- R2: The device byte is sent MSB first as prefix 10100, then strap bit 1, strap bit 0, then the direction bit (1 = read). On a full match the block pulls the data line low through the ninth clock. On any mismatch it stays released and ignores the bus until the next start.
- R3: While `busy_i` is high when a device byte completes, the byte is not acknowledged, whatever its direction bit.
- R4: In a write, the first two bytes after the device byte load the word pointer, high byte first, and each is acknowledged. Bits of the high byte at and above bit ADDR_W-8 are ignored.
- R5: Each later write byte is acknowledged and issues one `mem_wr_req` pulse carrying the pointer and the byte. The pointer's low PAGE_W bits then step by one and wrap inside the page, and the upper bits stay fixed.
- R6: A stop pulses `prog_start` for one cycle only if the transfer wrote at least one byte. A stop after an address-only write does not pulse it.
- R7: While `wp_i` is high, the device byte and both address bytes are acknowledged and the pointer still loads. The first data byte gets no acknowledge, and there is no write request and no `prog_start`.
- R8: A write carrying only the two address bytes, followed by a repeated start and a read device byte, returns the byte stored at the loaded address.
- R9: Read bytes leave MSB first, one bit per clock low phase, with the enable high for a 0 bit. The line is released for the master's acknowledge. A master acknowledge fetches the next byte from the pointer plus one, wrapping from the top address to 0.
- R10: After a master negative acknowledge the block stops sending, and the enable stays low until the next start.
- R11: A read that has no address phase starts at one past the last byte read or written.
- R12: The data enable changes only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the bus data line low |
| strap_a | input | 2 | Pin-strapped device address bits (tie unused to 0) |
| wp_i | input | 1 | Write protect, high blocks all writes |
| busy_i | input | 1 | Programming cycle in progress |
| mem_wr_req | output | 1 | One-cycle write request |
| mem_wr_addr | output | ADDR_W | Write word address |
| mem_wr_data | output | 8 | Write byte |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | ADDR_W | Read word address |
| mem_rd_data | input | 8 | Read byte, valid the cycle after `mem_rd_req` |
| prog_start | output | 1 | One-cycle pulse: commit written bytes |

## Verification
Two events can land in the same cycle. One is a start condition that cuts a byte short. The other is the bit shifter and byte-decision logic, which would otherwise fold the partial byte into the pointer. The bench provokes this by abandoning a high address byte after three bits, issuing a repeated start and then a read with no address phase. The returned byte must come from the pointer as it stood before the cut byte, which shows that the start took priority and no address was loaded. A second overlap is the next-byte fetch on a master acknowledge meeting the first bit of the following byte. It is judged by sequential reads across the top-address wrap.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

   // Frame controller states
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,   // ignore bus until a start
      ST_RX   = 3'd1,   // shifting in a byte
      ST_ACK  = 3'd2,   // slave drives the ninth bit
      ST_TX   = 3'd3,   // shifting out a read byte
      ST_MACK = 3'd4    // master drives the ninth bit
   } twi_state_e;

   // Meaning of the byte being received
   typedef enum logic [1:0] {
      BK_DEV  = 2'd0,
      BK_AHI  = 2'd1,
      BK_ALO  = 2'd2,
      BK_DATA = 2'd3
   } twi_kind_e;

   function automatic twi_kind_e kind_after(input twi_kind_e k);
      case (k)
         BK_DEV:  return BK_AHI;
         BK_AHI:  return BK_ALO;
         default: return BK_DATA;
      endcase
   endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_page,
   input  logic              inc_full,
   output logic [ADDR_W-1:0] ptr
);

   localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] page_nxt;
   logic [ADDR_W-1:0] full_nxt;

   assign full_nxt = ptr + A_ONE;

   generate
      if (PAGE_W >= ADDR_W) begin : g_flat
         assign page_nxt = full_nxt;
      end else begin : g_paged
         localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);
         logic [PAGE_W-1:0] low_nxt;
         assign low_nxt  = ptr[PAGE_W-1:0] + P_ONE;
         assign page_nxt = {ptr[ADDR_W-1:PAGE_W], low_nxt};

         // R5
         page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_page && !load) |=> $stable(ptr[ADDR_W-1:PAGE_W]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= '0;
      else if (load)     ptr <= load_val;
      else if (inc_page) ptr <= page_nxt;
      else if (inc_full) ptr <= full_nxt;
   end

endmodule

// File: rtl/twi_frame_ctl.sv
module twi_frame_ctl
   import twi_mem_pkg::*;
#(
   parameter int          ADDR_W     = 15,
   parameter logic [4:0]  DEV_PREFIX = 5'b10100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [1:0]        strap_a,
   input  logic              wp_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [7:0]        mem_rd_data,
   output logic              sda_oe,
   output logic              ptr_load,
   output logic [ADDR_W-1:0] ptr_load_val,
   output logic              ptr_inc_page,
   output logic              ptr_inc_full,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [7:0]        mem_wr_data,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic              prog_start
);

   localparam int HI_W = ADDR_W - 8;

   twi_state_e      state;
   twi_kind_e       kind;
   logic [3:0]      bit_cnt;
   logic [7:0]      rx_sr;
   logic [7:0]      tx_sr;
   logic [HI_W-1:0] hi_q;
   logic            rd_mode;
   logic            rd_wait;
   logic            mack_ok;
   logic            wrote;
   logic            dev_hit;

   assign dev_hit = (rx_sr[7:3] == DEV_PREFIX) && (rx_sr[2:1] == strap_a) && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         kind         <= BK_DEV;
         bit_cnt      <= '0;
         rx_sr        <= '0;
         tx_sr        <= '0;
         hi_q         <= '0;
         rd_mode      <= 1'b0;
         rd_wait      <= 1'b0;
         mack_ok      <= 1'b0;
         wrote        <= 1'b0;
         sda_oe       <= 1'b0;
         ptr_load     <= 1'b0;
         ptr_load_val <= '0;
         ptr_inc_page <= 1'b0;
         ptr_inc_full <= 1'b0;
         mem_wr_req   <= 1'b0;
         mem_wr_addr  <= '0;
         mem_wr_data  <= '0;
         mem_rd_req   <= 1'b0;
         mem_rd_addr  <= '0;
         prog_start   <= 1'b0;
      end else begin
         mem_wr_req   <= 1'b0;
         mem_rd_req   <= 1'b0;
         prog_start   <= 1'b0;
         ptr_load     <= 1'b0;
         ptr_inc_page <= 1'b0;
         ptr_inc_full <= 1'b0;
         rd_wait      <= mem_rd_req;
         if (rd_wait) tx_sr <= mem_rd_data;

         if (start_det) begin
            state   <= ST_RX;
            kind    <= BK_DEV;
            bit_cnt <= '0;
            rd_mode <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            if (wrote) prog_start <= 1'b1;
            wrote  <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && bit_cnt != 4'd8) begin
                     rx_sr   <= {rx_sr[6:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     case (kind)
                        BK_DEV: begin
                           if (dev_hit) begin
                              sda_oe  <= 1'b1;
                              state   <= ST_ACK;
                              rd_mode <= rx_sr[0];
                              if (rx_sr[0]) begin
                                 mem_rd_req   <= 1'b1;
                                 mem_rd_addr  <= ptr;
                                 ptr_inc_full <= 1'b1;
                              end
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        BK_AHI: begin
                           hi_q   <= rx_sr[HI_W-1:0];
                           sda_oe <= 1'b1;
                           state  <= ST_ACK;
                        end
                        BK_ALO: begin
                           ptr_load     <= 1'b1;
                           ptr_load_val <= {hi_q, rx_sr};
                           sda_oe       <= 1'b1;
                           state        <= ST_ACK;
                        end
                        default: begin
                           if (wp_i) begin
                              state <= ST_IDLE;
                           end else begin
                              mem_wr_req   <= 1'b1;
                              mem_wr_addr  <= ptr;
                              mem_wr_data  <= rx_sr;
                              ptr_inc_page <= 1'b1;
                              wrote        <= 1'b1;
                              sda_oe       <= 1'b1;
                              state        <= ST_ACK;
                           end
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rd_mode) begin
                        sda_oe <= ~tx_sr[7];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        kind   <= kind_after(kind);
                        state  <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                     end else begin
                        sda_oe  <= ~tx_sr[6];
                        tx_sr   <= {tx_sr[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_ok <= ~sda_s;
                     if (!sda_s) begin
                        mem_rd_req   <= 1'b1;
                        mem_rd_addr  <= ptr;
                        ptr_inc_full <= 1'b1;
                     end
                  end else if (scl_fall) begin
                     bit_cnt <= '0;
                     if (mack_ok) begin
                        sda_oe <= ~tx_sr[7];
                        state  <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

   // R5
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |=> !mem_wr_req);

   // R7
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> !$past(wp_i));

   // R6
   prog_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> $past(stop_det));

   // R9
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_req && mem_rd_req));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
   parameter int         ADDR_W      = 15,
   parameter int         PAGE_W      = 6,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] DEV_PREFIX  = 5'b10100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        strap_a,
   input  logic              wp_i,
   input  logic              busy_i,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [7:0]        mem_wr_data,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [7:0]        mem_rd_data,
   output logic              prog_start
);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("twi_mem_slave: ADDR_W must lie in 9..16");
      end
      if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page
         $error("twi_mem_slave: PAGE_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0] ptr;
   logic              ptr_load, ptr_inc_page, ptr_inc_full;
   logic [ADDR_W-1:0] ptr_load_val;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   twi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (ptr_load_val),
      .inc_page (ptr_inc_page),
      .inc_full (ptr_inc_full),
      .ptr      (ptr)
   );

   twi_frame_ctl #(.ADDR_W(ADDR_W), .DEV_PREFIX(DEV_PREFIX)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_s        (scl_s),
      .sda_s        (sda_s),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .start_det    (start_det),
      .stop_det     (stop_det),
      .strap_a      (strap_a),
      .wp_i         (wp_i),
      .busy_i       (busy_i),
      .ptr          (ptr),
      .mem_rd_data  (mem_rd_data),
      .sda_oe       (sda_oe),
      .ptr_load     (ptr_load),
      .ptr_load_val (ptr_load_val),
      .ptr_inc_page (ptr_inc_page),
      .ptr_inc_full (ptr_inc_full),
      .mem_wr_req   (mem_wr_req),
      .mem_wr_addr  (mem_wr_addr),
      .mem_wr_data  (mem_wr_data),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_addr  (mem_rd_addr),
      .prog_start   (prog_start)
   );

endmodule

// File: tb/twi_mem_slave_test.sv
`timescale 1ns/1ps
module twi_mem_slave_test;

   localparam int AW = 15;
   localparam int Q  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic [1:0]    strap_a = 2'b10;
   logic          wp_i = 1'b0;
   logic          busy_i = 1'b0;
   logic          sda_oe, mem_wr_req, mem_rd_req, prog_start;
   logic [AW-1:0] mem_wr_addr, mem_rd_addr;
   logic [7:0]    mem_wr_data;
   logic [7:0]    mem_rd_data = 8'h00;
   wire           sda_bus = sda_m & ~sda_oe;

   int n_chk = 0, n_fail = 0;
   int wr_cnt = 0, prog_cnt = 0, oe_viol = 0;
   bit oe_seen = 1'b0, done = 1'b0;
   logic [AW-1:0] wr_addr_log [0:15];
   logic [7:0]    wr_data_log [0:15];
   logic          oe_prev = 1'b0;

   always #4 clk = ~clk;

   twi_mem_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .strap_a(strap_a), .wp_i(wp_i), .busy_i(busy_i),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .prog_start(prog_start)
   );

   function automatic logic [7:0] model(input logic [AW-1:0] a);
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h96;
   endfunction

   always @(posedge clk) if (mem_rd_req) mem_rd_data <= model(mem_rd_addr);

   always @(negedge clk) begin
      if (mem_wr_req && wr_cnt < 16) begin
         wr_addr_log[wr_cnt] = mem_wr_addr;
         wr_data_log[wr_cnt] = mem_wr_data;
      end
      if (mem_wr_req) wr_cnt++;
      if (prog_start) prog_cnt++;
      if (sda_oe) oe_seen = 1'b1;
      if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
      oe_prev = sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      ack = !sda_bus;
      tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic rd_byte(input bit mack, output logic [7:0] b);
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
         b = {b[6:0], sda_bus};
         tick(Q); scl_m = 1'b0; tick(Q);
      end
      sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic t_reset();
      chk(sda_oe == 1'b0, "R1 reset enable", sda_oe, 0);
      chk(mem_wr_req == 1'b0 && mem_rd_req == 1'b0, "R1 reset requests", mem_wr_req, 0);
   endtask

   task automatic t_wrong_dev();
      bit a;
      bus_start(); send_byte(8'hA2, a);
      chk(!a, "R2 strap mismatch nack", a, 0);
      send_byte(8'hA4, a);
      chk(!a, "R2 ignored until start", a, 0);
      bus_stop();
   endtask

   task automatic t_byte_write();
      bit a0, a1, a2, a3;
      bus_start(); send_byte(8'hA4, a0); send_byte(8'hC1, a1);
      send_byte(8'h3E, a2); send_byte(8'h5A, a3); bus_stop(); tick(4);
      chk(a0, "R2 match ack", a0, 1);
      chk(a1 && a2, "R4 address acks", {a1, a2}, 3);
      chk(a3 && wr_cnt == 1, "R5 one write", wr_cnt, 1);
      chk(wr_addr_log[0] == 15'h413E, "R4 high bit ignored", wr_addr_log[0], 15'h413E);
      chk(wr_data_log[0] == 8'h5A, "R5 write data", wr_data_log[0], 8'h5A);
      chk(prog_cnt == 1, "R6 commit pulse", prog_cnt, 1);
   endtask

   task automatic t_page_write();
      bit a;
      logic [7:0] d [3] = '{8'h11, 8'h22, 8'h33};
      logic [AW-1:0] ea [3] = '{15'h027E, 15'h027F, 15'h0240};
      bus_start(); send_byte(8'hA4, a); send_byte(8'h02, a); send_byte(8'h7E, a);
      for (int i = 0; i < 3; i++) send_byte(d[i], a);
      bus_stop(); tick(4);
      chk(wr_cnt == 4, "R5 page write count", wr_cnt, 4);
      for (int i = 0; i < 3; i++)
         chk(wr_addr_log[i+1] == ea[i] && wr_data_log[i+1] == d[i], "R5 page wrap",
             wr_addr_log[i+1], ea[i]);
      chk(prog_cnt == 2, "R6 commit after page", prog_cnt, 2);
   endtask

   task automatic t_cur_read(input logic [AW-1:0] exp_a, input string tag);
      bit a; logic [7:0] b;
      bus_start(); send_byte(8'hA5, a); rd_byte(1'b0, b); bus_stop();
      chk(a && b == model(exp_a), tag, b, model(exp_a));
   endtask

   task automatic t_rand_read();
      bit a, x; logic [7:0] b0, b1;
      bus_start(); send_byte(8'hA4, a); send_byte(8'h12, a); send_byte(8'h34, a);
      bus_start(); send_byte(8'hA5, a);
      rd_byte(1'b1, b0); rd_byte(1'b0, b1);
      chk(b0 == model(15'h1234), "R8 random read", b0, model(15'h1234));
      chk(b1 == model(15'h1235), "R9 sequential next", b1, model(15'h1235));
      oe_seen = 1'b0;
      send_byte(8'hFF, x);
      chk(!oe_seen && !x, "R10 silent after nack", oe_seen, 0);
      bus_stop(); tick(4);
      chk(prog_cnt == 2, "R6 no commit for address-only write", prog_cnt, 2);
   endtask

   task automatic t_wrap_read();
      bit a; logic [7:0] b0, b1, b2;
      bus_start(); send_byte(8'hA4, a); send_byte(8'h7F, a); send_byte(8'hFF, a);
      bus_start(); send_byte(8'hA5, a);
      rd_byte(1'b1, b0); rd_byte(1'b1, b1); rd_byte(1'b0, b2); bus_stop();
      chk(b0 == model(15'h7FFF), "R9 top address", b0, model(15'h7FFF));
      chk(b1 == model(15'h0000), "R9 wrap to zero", b1, model(15'h0000));
      chk(b2 == model(15'h0001), "R9 after wrap", b2, model(15'h0001));
   endtask

   task automatic t_restart_mid();
      bit a, h;
      bus_start(); send_byte(8'hA4, a); send_byte(8'h00, h);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      chk(a && h, "R1 setup acks", {a, h}, 3);
      t_cur_read(15'h0002, "R1 start cuts byte");
   endtask

   task automatic t_busy();
      bit a;
      busy_i = 1'b1;
      bus_start(); send_byte(8'hA4, a);
      chk(!a, "R3 busy write poll nack", a, 0);
      bus_start(); send_byte(8'hA5, a);
      chk(!a, "R3 busy read nack", a, 0);
      bus_stop(); busy_i = 1'b0;
      bus_start(); send_byte(8'hA4, a); bus_stop(); tick(4);
      chk(a, "R3 ack once idle", a, 1);
      chk(prog_cnt == 2, "R6 poll gives no commit", prog_cnt, 2);
   endtask

   task automatic t_wp();
      bit a0, a1, a2, a3;
      wp_i = 1'b1;
      bus_start(); send_byte(8'hA4, a0); send_byte(8'h01, a1);
      send_byte(8'h00, a2); send_byte(8'h77, a3); bus_stop(); tick(4);
      wp_i = 1'b0;
      chk(a0 && a1 && a2, "R7 header acked", {a0, a1, a2}, 7);
      chk(!a3, "R7 data nack", a3, 0);
      chk(wr_cnt == 4 && prog_cnt == 2, "R7 nothing written", wr_cnt, 4);
      t_cur_read(15'h0100, "R7 pointer loaded not stepped");
   endtask

   initial begin
      tick(5); rst_n = 1'b1; tick(5);
      t_reset();
      t_wrong_dev();
      t_byte_write();
      t_cur_read(15'h413F, "R11 read after byte write");
      t_page_write();
      t_cur_read(15'h0241, "R11 read after page wrap");
      t_rand_read();
      t_wrap_read();
      t_restart_mid();
      t_busy();
      t_wp();
      chk(oe_viol == 0, "R12 enable moved with clock high", oe_viol, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule